// File: doc/BRIEF.md
# DDR Write Burst Truncation Sequencer

This block drives the command side of a DDR SDRAM for one special access: a WRITE whose burst is cut short on purpose by a PRECHARGE. A request names a bank, a starting column, a burst length of 4 or 8, a burst order (sequential or interleaved), how many leading burst elements are really to be stored, whether the closing precharge covers one bank or all banks, and the data for the whole aligned column block. The sequencer issues the WRITE and streams the data as rising/falling element pairs, one pair per clock. It masks the unwanted elements that still fall before the precharge point. It waits out write recovery counted from the last kept pair, issues the PRECHARGE, waits out the precharge time with NOPs, and then pulses done.

The control is one state machine. Its states are IDLE, ISSUE_WR, STREAM, ISSUE_PRE, PRE_WAIT, FINISH and REJECT. The transitions are: accept (IDLE to ISSUE_WR on a valid request with a legal keep count), refuse (IDLE to REJECT on an illegal one), open_data (ISSUE_WR to STREAM), recovered (STREAM to ISSUE_PRE once write recovery has elapsed), close_short (ISSUE_PRE to FINISH when the precharge time is one cycle), close_long (ISSUE_PRE to PRE_WAIT otherwise), settled (PRE_WAIT to FINISH), and retire (FINISH or REJECT back to IDLE). The first data pair sits at the nominal strobe position, one clock after the WRITE.

The write-recovery time `TWR` and the precharge time `TRP` are parameters in whole clocks, each at least 1. The strobe delay line, refresh and row activation are handled elsewhere.

Top module: `wtr_seq`

## Requirements
- R1: A request whose keep count is 0, or larger than its burst length (4 when `req_bl8`=0, 8 when 1), makes `err` high for exactly the one cycle after the accepting edge, issues no command (`cmd` stays 0), and returns the block to idle the cycle after.
- R2: In the cycle after a legal request is accepted, `cmd` is 1 (WRITE), `ba` is the requested bank, `addr` holds the column in its low bits and `addr[8]` is 0, so auto precharge is off.
- R3: Element e of the burst (e counted from 0) travels in pair p = e/2, in the clock p+1 cycles after the WRITE: even e on `dq_r`, odd e on `dq_f`, with `dqs_en` high. In sequential order element e carries `req_data` slot ((col + e) mod BL), where slot j occupies bits [j*DW +: DW] and BL is 4 or 8.
- R4: In interleaved order (`req_ilv`=1), element e carries slot ((col XOR e) mod BL).
- R5: On every driven pair, an element with index e >= keep has its DM bit high (write inhibited). An element below keep has DM low. This includes the falling half of the last pair when keep is odd.
- R6: A pair whose clock is at or after the PRECHARGE, or whose index is beyond the burst, is dropped: `dqs_en`, `dm_r` and `dm_f` are low and `dq_r`/`dq_f` are zero.
- R7: PRECHARGE (`cmd`=2) is issued exactly ceil(keep/2)+TWR cycles after the WRITE, to the same bank, with `addr[8]` equal to `req_all` (1 = all banks).
- R8: Every cycle between WRITE and PRECHARGE, and every cycle after PRECHARGE, carries NOP (`cmd`=0). `done` is high for exactly one cycle, TRP cycles after the PRECHARGE.
- R9: `busy` is high from the WRITE (or reject) cycle until the cycle after `done`. A request presented while busy is ignored and leaves the command and data streams unchanged.
- R10: After reset `cmd` is NOP and `busy`, `dqs_en`, `dm_r`, `dm_f`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken only when idle |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_bl8 | input | 1 | Burst length: 0 = 4, 1 = 8 |
| req_ilv | input | 1 | Burst order: 0 = sequential, 1 = interleaved |
| req_keep | input | 4 | Number of leading elements to store |
| req_all | input | 1 | Close with an all-banks precharge |
| req_data | input | 8*DW | Data by column slot within the aligned block |
| busy | output | 1 | Sequence in progress |
| cmd | output | 2 | 0 NOP, 1 WRITE, 2 PRECHARGE |
| ba | output | BA_W | Bank address |
| addr | output | AW | Address; bit 8 is the auto-precharge / all-banks flag |
| dqs_en | output | 1 | Strobe toggles this clock |
| dq_r | output | DW | Rising-half data element |
| dq_f | output | DW | Falling-half data element |
| dm_r | output | 1 | Rising-half mask, high = inhibit |
| dm_f | output | 1 | Falling-half mask, high = inhibit |
| done | output | 1 | Sequence complete, one-cycle pulse |
| err | output | 1 | Request refused, one-cycle pulse |

## Verification
The directed scenarios aim at the point where masking stops and dropping starts. A burst of 8 keeping two elements must mask pair 1 and leave pairs 2 and 3 undriven. A design that masks through the whole burst would toggle the strobe under the PRECHARGE, and one that never masks would let pair 1 land. Odd keep counts check the falling-half mask; a design that rounds keep up to a pair would store one extra element. A burst of 4 keeping all four checks that the pair beyond the burst is dropped, not repeated. Sequential and interleaved orders with unaligned columns expose slot wrap errors. A request held high while busy exposes a sequencer that restarts in mid-burst, and illegal keep counts of 0, 5 with a burst of 4, and 9 expose a design that issues a WRITE it cannot finish correctly.

// File: rtl/wtr_pkg.sv
package wtr_pkg;

    localparam int BLK    = 8;   // elements in the largest burst block
    localparam int KEEP_W = 4;   // width of the keep count
    localparam int OFF_W  = 3;   // element index width

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_PRE   = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE_WR,
        S_STREAM,
        S_ISSUE_PRE,
        S_PRE_WAIT,
        S_FINISH,
        S_REJECT
    } state_e;

endpackage

// File: rtl/wtr_order.sv
module wtr_order
    import wtr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [OFF_W-1:0]  col_lo,
    input  logic              bl8,
    input  logic              ilv,
    input  logic [BLK*DW-1:0] slots,
    output logic [DW-1:0]     beat [BLK]
);

    logic [DW-1:0] slot_arr [BLK];

    for (genvar j = 0; j < BLK; j++) begin : g_slot
        assign slot_arr[j] = slots[j*DW +: DW];
    end

    // Element i of the burst takes the slot picked by the burst order;
    // a short burst wraps inside a four-slot block.
    for (genvar i = 0; i < BLK; i++) begin : g_beat
        logic [OFF_W-1:0] lin_off;
        logic [OFF_W-1:0] xor_off;
        logic [OFF_W-1:0] sel_off;
        always_comb begin
            lin_off = col_lo + OFF_W'(i);
            xor_off = col_lo ^ OFF_W'(i);
            sel_off = ilv ? xor_off : lin_off;
            if (!bl8) begin
                sel_off[OFF_W-1] = 1'b0;
            end
            beat[i] = slot_arr[sel_off];
        end
    end

endmodule

// File: rtl/wtr_beatplan.sv
module wtr_beatplan
    import wtr_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic              active,
    input  logic [TW-1:0]     t,
    input  logic [KEEP_W-1:0] keep,
    input  logic              bl8,
    output logic              drive,
    output logic [OFF_W-1:0]  elem_r,
    output logic [OFF_W-1:0]  elem_f,
    output logic              mask_r,
    output logic              mask_f
);

    localparam int EW = (TW + 1 > KEEP_W) ? TW + 1 : KEEP_W;

    logic [TW-1:0] pair;
    logic [TW-1:0] pairs_in_burst;
    logic [EW-1:0] e_rise;
    logic [EW-1:0] e_fall;
    logic [EW-1:0] keep_x;

    always_comb begin
        pair           = t - TW'(1);
        pairs_in_burst = bl8 ? TW'(4) : TW'(2);
        e_rise         = {{(EW-TW){1'b0}}, pair} << 1;
        e_fall         = e_rise | EW'(1);
        keep_x         = EW'(keep);
        drive          = active && (pair < pairs_in_burst);
        elem_r         = e_rise[OFF_W-1:0];
        elem_f         = e_fall[OFF_W-1:0];
        mask_r         = drive && (e_rise >= keep_x);
        mask_f         = drive && (e_fall >= keep_x);
    end

endmodule

// File: rtl/wtr_seq.sv
module wtr_seq
    import wtr_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int COL_W  = 8,
    parameter int AW     = 12,
    parameter int DW     = 32,
    parameter int AP_BIT = 8,
    parameter int TWR    = 2,
    parameter int TRP    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [BA_W-1:0]     req_bank,
    input  logic [COL_W-1:0]    req_col,
    input  logic                req_bl8,
    input  logic                req_ilv,
    input  logic [3:0]          req_keep,
    input  logic                req_all,
    input  logic [8*DW-1:0]     req_data,
    output logic                busy,
    output logic [1:0]          cmd,
    output logic [BA_W-1:0]     ba,
    output logic [AW-1:0]       addr,
    output logic                dqs_en,
    output logic [DW-1:0]       dq_r,
    output logic [DW-1:0]       dq_f,
    output logic                dm_r,
    output logic                dm_f,
    output logic                done,
    output logic                err
);

    localparam int TW = $clog2(BLK/2 + TWR + TRP + 2);

    if (TWR < 1 || TRP < 1) begin : g_bad_timing
        initial $error("TWR and TRP must be at least 1");
    end
    if (COL_W > AP_BIT || AP_BIT >= AW) begin : g_bad_addr
        initial $error("column must sit below the auto-precharge bit");
    end

    state_e              state;
    logic [TW-1:0]       t;
    logic [BA_W-1:0]     r_bank;
    logic [COL_W-1:0]    r_col;
    logic                r_bl8;
    logic                r_ilv;
    logic [KEEP_W-1:0]   r_keep;
    logic                r_all;
    logic [BLK*DW-1:0]   r_data;

    logic                keep_ok;
    logic [KEEP_W-1:0]   kept_pairs;
    logic [TW-1:0]       pre_t;

    logic [DW-1:0]       beat [BLK];
    logic                pl_drive;
    logic [OFF_W-1:0]    pl_er;
    logic [OFF_W-1:0]    pl_ef;
    logic                pl_mr;
    logic                pl_mf;

    always_comb begin
        keep_ok    = (req_keep != '0) &&
                     (req_keep <= (req_bl8 ? KEEP_W'(8) : KEEP_W'(4)));
        kept_pairs = (r_keep + KEEP_W'(1)) >> 1;
        pre_t      = TW'(kept_pairs) + TW'(TWR);
    end

    wtr_order #(.DW(DW)) u_order (
        .col_lo (r_col[OFF_W-1:0]),
        .bl8    (r_bl8),
        .ilv    (r_ilv),
        .slots  (r_data),
        .beat   (beat)
    );

    wtr_beatplan #(.TW(TW)) u_plan (
        .active (state == S_STREAM),
        .t      (t),
        .keep   (r_keep),
        .bl8    (r_bl8),
        .drive  (pl_drive),
        .elem_r (pl_er),
        .elem_f (pl_ef),
        .mask_r (pl_mr),
        .mask_f (pl_mf)
    );

    // State register and request capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            t      <= '0;
            r_bank <= '0;
            r_col  <= '0;
            r_bl8  <= 1'b0;
            r_ilv  <= 1'b0;
            r_keep <= '0;
            r_all  <= 1'b0;
            r_data <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    t <= '0;
                    if (req_valid) begin
                        r_bank <= req_bank;
                        r_col  <= req_col;
                        r_bl8  <= req_bl8;
                        r_ilv  <= req_ilv;
                        r_keep <= req_keep;
                        r_all  <= req_all;
                        r_data <= req_data;
                        state  <= keep_ok ? S_ISSUE_WR : S_REJECT;
                    end
                end
                S_ISSUE_WR: begin
                    t     <= TW'(1);
                    state <= S_STREAM;
                end
                S_STREAM: begin
                    t <= t + TW'(1);
                    if (t == pre_t - TW'(1)) begin
                        state <= S_ISSUE_PRE;
                    end
                end
                S_ISSUE_PRE: begin
                    t     <= TW'(1);
                    state <= (TRP == 1) ? S_FINISH : S_PRE_WAIT;
                end
                S_PRE_WAIT: begin
                    t <= t + TW'(1);
                    if (t == TW'(TRP - 1)) begin
                        state <= S_FINISH;
                    end
                end
                S_FINISH: begin
                    state <= S_IDLE;
                end
                S_REJECT: begin
                    state <= S_IDLE;
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end

    // Output decode.
    always_comb begin
        cmd    = CMD_NOP;
        ba     = r_bank;
        addr   = '0;
        dqs_en = 1'b0;
        dq_r   = '0;
        dq_f   = '0;
        dm_r   = 1'b0;
        dm_f   = 1'b0;
        done   = 1'b0;
        err    = 1'b0;
        busy   = (state != S_IDLE);
        unique case (state)
            S_IDLE: begin
            end
            S_ISSUE_WR: begin
                cmd          = CMD_WRITE;
                addr         = AW'(r_col);
                addr[AP_BIT] = 1'b0;
            end
            S_STREAM: begin
                if (pl_drive) begin
                    dqs_en = 1'b1;
                    dq_r   = beat[pl_er];
                    dq_f   = beat[pl_ef];
                    dm_r   = pl_mr;
                    dm_f   = pl_mf;
                end
            end
            S_ISSUE_PRE: begin
                cmd          = CMD_PRE;
                addr[AP_BIT] = r_all;
            end
            S_PRE_WAIT: begin
            end
            S_FINISH: begin
                done = 1'b1;
            end
            S_REJECT: begin
                err = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/wtr_seq_chk.sv
module wtr_seq_chk #(
    parameter int BA_W = 2,
    parameter int TRP  = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      cmd,
    input logic [BA_W-1:0] ba,
    input logic            ap_bit,
    input logic            dqs_en,
    input logic            dm_r,
    input logic            dm_f,
    input logic            done,
    input logic            err,
    input logic            busy
);

    localparam int CW  = $clog2(TRP + 2);
    localparam int SAT = TRP + 1;

    logic [CW-1:0]   since_pre;
    logic [BA_W-1:0] wr_bank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_pre <= CW'(SAT);
            wr_bank   <= '0;
        end else begin
            if (cmd == 2'd2) begin
                since_pre <= CW'(1);
            end else if (since_pre != CW'(SAT)) begin
                since_pre <= since_pre + CW'(1);
            end
            if (cmd == 2'd1) begin
                wr_bank <= ba;
            end
        end
    end

    a_r1_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cmd == 2'd0));

    a_r2_no_autopre: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1) |-> !ap_bit);

    a_r5_mask_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_r || dm_f) |-> dqs_en);

    a_r6_no_strobe_at_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd2) |-> (!dqs_en && !dm_r && !dm_f));

    a_r7_pre_same_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd2) |-> (ba == wr_bank));

    a_r8_done_after_trp: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_pre == CW'(TRP)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_write_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1) |-> !$past(busy));

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

endmodule

bind wtr_seq wtr_seq_chk #(.BA_W(BA_W), .TRP(TRP)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .ba     (ba),
    .ap_bit (addr[AP_BIT]),
    .dqs_en (dqs_en),
    .dm_r   (dm_r),
    .dm_f   (dm_f),
    .done   (done),
    .err    (err),
    .busy   (busy)
);

// File: tb/sim_wtr_seq.sv
module sim_wtr_seq;

    localparam int BA_W = 2;
    localparam int COL_W = 8;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int TWR = 2;
    localparam int TRP = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [BA_W-1:0]   req_bank = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              req_bl8 = 1'b0;
    logic              req_ilv = 1'b0;
    logic [3:0]        req_keep = '0;
    logic              req_all = 1'b0;
    logic [8*DW-1:0]   req_data = '0;
    logic              busy;
    logic [1:0]        cmd;
    logic [BA_W-1:0]   ba;
    logic [AW-1:0]     addr;
    logic              dqs_en;
    logic [DW-1:0]     dq_r;
    logic [DW-1:0]     dq_f;
    logic              dm_r;
    logic              dm_f;
    logic              done;
    logic              err;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    wtr_seq #(.BA_W(BA_W), .COL_W(COL_W), .AW(AW), .DW(DW),
              .AP_BIT(8), .TWR(TWR), .TRP(TRP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
        .req_col(req_col), .req_bl8(req_bl8), .req_ilv(req_ilv),
        .req_keep(req_keep), .req_all(req_all), .req_data(req_data),
        .busy(busy), .cmd(cmd), .ba(ba), .addr(addr), .dqs_en(dqs_en),
        .dq_r(dq_r), .dq_f(dq_f), .dm_r(dm_r), .dm_f(dm_f),
        .done(done), .err(err));

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ctl_vec(logic [1:0] c, logic q, logic mr, logic mf,
                                           logic d, logic e, logic b);
        return {c, q, mr, mf, d, e, b};
    endfunction

    function automatic logic [DW-1:0] slot_val(int seed, int j);
        return DW'((seed << 16) | 32'h0000_A500 | j);
    endfunction

    function automatic int slot_of(int col, int e, bit bl8, bit ilv);
        int m;
        m = bl8 ? 8 : 4;
        return ilv ? ((col ^ e) % m) : ((col + e) % m);
    endfunction

    // Runs one legal request and checks every cycle until idle again.
    // With noise set, a different request is held on the inputs while busy (R9).
    task automatic run_req(input string name, input int bank, input int col,
                           input bit bl8, input bit ilv, input int keep,
                           input bit all, input int seed, input bit noise);
        int np;
        int pre_t;
        int bp;
        int last;
        string dtag;
        req_bank = BA_W'(bank);
        req_col  = COL_W'(col);
        req_bl8  = bl8;
        req_ilv  = ilv;
        req_keep = 4'(keep);
        req_all  = all;
        for (int j = 0; j < 8; j++) req_data[j*DW +: DW] = slot_val(seed, j);
        req_valid = 1'b1;
        np    = (keep + 1) / 2;
        pre_t = np + TWR;
        bp    = bl8 ? 4 : 2;
        last  = pre_t + TRP + 1;
        dtag  = noise ? "R9" : (ilv ? "R4" : "R3");
        @(negedge clk);
        for (int t = 0; t <= last; t++) begin
            if (t == 0) begin
                req_valid = noise;
                if (noise) begin
                    req_bank = ~BA_W'(bank);
                    req_col  = COL_W'(col + 3);
                    req_keep = 4'd1;
                    req_data = '1;
                end
            end
            if (noise && t == pre_t + TRP - 1) req_valid = 1'b0;
            if (t == 0) begin
                chk({name, " R2 write ctl"}, 64'(ctl_vec(cmd, dqs_en, dm_r, dm_f, done, err, busy)),
                    64'(ctl_vec(2'd1, 0, 0, 0, 0, 0, 1)));
                chk({name, " R2 write ba/addr"}, {50'd0, ba, addr},
                    {50'd0, BA_W'(bank), AW'(col)});
            end else if (t < pre_t) begin
                int p;
                p = t - 1;
                if (p < bp) begin
                    logic mr;
                    logic mf;
                    mr = (2*p >= keep);
                    mf = (2*p + 1 >= keep);
                    chk({name, (mr || mf) ? " R5 masked pair ctl" : " R3 data pair ctl"},
                        64'(ctl_vec(cmd, dqs_en, dm_r, dm_f, done, err, busy)),
                        64'(ctl_vec(2'd0, 1, mr, mf, 0, 0, 1)));
                    chk({name, " ", dtag, " rise/fall data"}, {dq_r, dq_f},
                        {slot_val(seed, slot_of(col, 2*p, bl8, ilv)),
                         slot_val(seed, slot_of(col, 2*p + 1, bl8, ilv))});
                end else begin
                    chk({name, " R6 beyond-burst pair dropped"},
                        {22'd0, dq_r, dq_f, ctl_vec(cmd, dqs_en, dm_r, dm_f, done, err, busy)},
                        {22'd0, 64'd0, ctl_vec(2'd0, 0, 0, 0, 0, 0, 1)});
                end
            end else if (t == pre_t) begin
                chk({name, " R7 precharge ctl, R6 dropped pair"},
                    {22'd0, dq_r, dq_f, ctl_vec(cmd, dqs_en, dm_r, dm_f, done, err, busy)},
                    {22'd0, 64'd0, ctl_vec(2'd2, 0, 0, 0, 0, 0, 1)});
                chk({name, " R7 precharge bank/all"}, {62'd0, ba, addr[8]},
                    {62'd0, BA_W'(bank), all});
            end else if (t < pre_t + TRP) begin
                chk({name, " R8 tRP wait NOP"},
                    64'(ctl_vec(cmd, dqs_en, dm_r, dm_f, done, err, busy)),
                    64'(ctl_vec(2'd0, 0, 0, 0, 0, 0, 1)));
            end else if (t == pre_t + TRP) begin
                chk({name, " R8 done pulse"},
                    64'(ctl_vec(cmd, dqs_en, dm_r, dm_f, done, err, busy)),
                    64'(ctl_vec(2'd0, 0, 0, 0, 1, 0, 1)));
            end else begin
                chk({name, " R9 idle after done"},
                    64'(ctl_vec(cmd, dqs_en, dm_r, dm_f, done, err, busy)),
                    64'(ctl_vec(2'd0, 0, 0, 0, 0, 0, 0)));
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic run_reject(input string name, input bit bl8, input int keep);
        req_bank  = 2'd1;
        req_col   = 8'd2;
        req_bl8   = bl8;
        req_ilv   = 1'b0;
        req_keep  = 4'(keep);
        req_all   = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({name, " R1 reject cycle"},
            64'(ctl_vec(cmd, dqs_en, dm_r, dm_f, done, err, busy)),
            64'(ctl_vec(2'd0, 0, 0, 0, 0, 1, 1)));
        @(negedge clk);
        chk({name, " R1 back to idle"},
            64'(ctl_vec(cmd, dqs_en, dm_r, dm_f, done, err, busy)),
            64'(ctl_vec(2'd0, 0, 0, 0, 0, 0, 0)));
        @(negedge clk);
        chk({name, " R1 no command after reject"}, 64'(cmd), 64'd0);
    endtask

    task automatic test_reset;
        @(negedge clk);
        chk("R10 reset state", 64'(ctl_vec(cmd, dqs_en, dm_r, dm_f, done, err, busy)),
            64'(ctl_vec(2'd0, 0, 0, 0, 0, 0, 0)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_req("bl4 keep2", 1, 8'h10, 0, 0, 2, 0, 1, 0);
        run_req("bl8 keep2", 2, 8'h20, 1, 0, 2, 0, 2, 0);
        run_req("bl8 keep3 col5 seq", 3, 8'h45, 1, 0, 3, 0, 3, 0);
        run_req("bl8 keep8 col3 ilv", 0, 8'h33, 1, 1, 8, 1, 4, 0);
        run_req("bl4 keep1 col6 ilv all", 2, 8'h06, 0, 1, 1, 1, 5, 0);
        run_req("bl4 keep4 col3", 1, 8'h03, 0, 0, 4, 0, 6, 0);
        run_req("bl8 keep5 all", 3, 8'h7E, 1, 0, 5, 1, 7, 0);
        run_req("busy noise", 1, 8'h12, 1, 0, 6, 0, 8, 1);
        run_reject("keep0", 1, 0);
        run_reject("keep5 bl4", 0, 5);
        run_reject("keep9 bl8", 1, 9);
        run_req("after reject", 0, 8'h01, 1, 1, 7, 0, 9, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule